// File: doc/BRIEF.md
# Backplane Slot Bus Arbiter

This block lives on the bus-master card of a card-cage backplane and decides which peripheral slot may talk on the shared, half-duplex differential slow bus. Each slot has three signals. The slot pulls its active-low request line to ask for the bus. The arbiter pulls that slot's active-low select line to grant it. A presence-detect loop tells the arbiter whether a card is plugged in. A card may drive the shared bus only while its select is low, so the arbiter keeps at most one select low at any time.

Slot 0 belongs to the bus master and never takes part. The other slots are served round-robin. The search starts at the slot after the one granted most recently. Requests and presence pass through a two-flop synchroniser before use. A grant ends in one of three ways: the card releases its request, the card disappears, or a programmable hold limit runs out. When the limit runs out, a sticky per-slot timeout flag is set. After every grant, all selects stay high for a guard gap before the next grant.

The controller is a four-state machine:
- `ST_IDLE` waits for an eligible request and moves to `ST_BUSY` with the chosen slot.
- `ST_BUSY` holds the select. It leaves to `ST_GAP1` on release, on loss of presence, or on timeout.
- `ST_GAP1` always moves to `ST_GAP2`.
- `ST_GAP2` always returns to `ST_IDLE`.

Top module: `slot_bus_arbiter`

## Requirements
- R1: While reset is asserted and just after it, every `sel_n` bit is 1 and every `tmo_flag` bit is 0. The round-robin pointer starts so that slot 1 is the first candidate.
- R2: `req_n` and `pres_n` are used only after two synchronising flops. A request that is steady before rising edge 1 on an idle arbiter makes its select low after rising edge 3.
- R3: At most one `sel_n` bit is low in any cycle.
- R4: A slot whose `pres_n` is 1 (no card; a low value means present) is never newly granted. Losing presence ends a running grant in the same way as a release.
- R5: Slot 0 is never selected, whatever its request and presence lines do.
- R6: Among eligible slots, the grant goes to the first one found by counting upward from the last granted slot. Counting wraps from slot NSLOT-1 back to slot 1.
- R7: When the granted card sets its `req_n` to 1 before rising edge 1, its select returns high after rising edge 3.
- R8: Between the end of one grant and the start of the next, all selects stay high for at least two cycles. This design gives three.
- R9: A select stays low for at most `hold_limit` cycles, where a limit of 0 counts as 1. When the limit forces a grant to end, `tmo_flag` for that slot goes to 1 in the same cycle the select returns high, and it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_n | input | NSLOT | Per-slot bus request, active low |
| pres_n | input | NSLOT | Per-slot presence loop, low when a card is fitted |
| hold_limit | input | TMO_W | Longest grant in cycles (0 treated as 1) |
| sel_n | output | NSLOT | Per-slot bus select, active low |
| tmo_flag | output | NSLOT | Sticky per-slot timeout flag |

## Verification
A wrong owner register or a wrong round-robin pointer shows up as a select going low on the wrong slot on the first grant after the fault. It is caught within one cycle by the per-cycle reference comparison and by the recorded grant order. A stuck state or a wrong hold counter shows up as a select that stays low too long, a missing or shortened guard gap, or a timeout flag that appears, moves or clears at the wrong time. The per-cycle comparison catches each of these in the cycle where it first differs.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_GAP1 = 2'd2,
        ST_GAP2 = 2'd3
    } arb_state_t;
endpackage

// File: rtl/slot_sync.sv
module slot_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int NSLOT = 8,
    parameter int IDX_W = $clog2(NSLOT)
) (
    input  logic [NSLOT-1:0] elig,
    input  logic [IDX_W-1:0] last,
    output logic             found,
    output logic [IDX_W-1:0] pick
);
    localparam int NPER = NSLOT - 1;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 1; k <= NPER; k++) begin
            int cand;
            cand = ((int'(last) - 1 + k) % NPER) + 1;
            if (!found && elig[cand]) begin
                found = 1'b1;
                pick  = IDX_W'(cand);
            end
        end
    end
endmodule

// File: rtl/slot_bus_arbiter.sv
module slot_bus_arbiter
    import arb_pkg::*;
#(
    parameter int NSLOT = 8,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] req_n,
    input  logic [NSLOT-1:0] pres_n,
    input  logic [TMO_W-1:0] hold_limit,
    output logic [NSLOT-1:0] sel_n,
    output logic [NSLOT-1:0] tmo_flag
);
    localparam int IDX_W = $clog2(NSLOT);
    localparam logic [NSLOT-1:0] PERIPH_MASK = {{(NSLOT-1){1'b1}}, 1'b0};
    localparam logic [IDX_W-1:0] LAST_INIT = IDX_W'(NSLOT - 1);

    logic [NSLOT-1:0] req_s, pres_s, elig;
    logic             found;
    logic [IDX_W-1:0] pick;

    arb_state_t       state_q, state_d;
    logic [IDX_W-1:0] owner_q, owner_d, last_q, last_d;
    logic [TMO_W-1:0] cnt_q, cnt_d, eff_lim;
    logic [NSLOT-1:0] flag_q, flag_d;

    slot_sync #(.W(NSLOT)) i_req_sync (
        .clk(clk), .rst_n(rst_n), .d(~req_n), .q(req_s)
    );
    slot_sync #(.W(NSLOT)) i_pres_sync (
        .clk(clk), .rst_n(rst_n), .d(~pres_n), .q(pres_s)
    );

    assign elig    = req_s & pres_s & PERIPH_MASK;
    assign eff_lim = (hold_limit == '0) ? TMO_W'(1) : hold_limit;

    rr_pick #(.NSLOT(NSLOT), .IDX_W(IDX_W)) i_pick (
        .elig(elig), .last(last_q), .found(found), .pick(pick)
    );

    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        last_d  = last_q;
        cnt_d   = cnt_q;
        flag_d  = flag_q;
        unique case (state_q)
            ST_IDLE: begin
                if (found) begin
                    state_d = ST_BUSY;
                    owner_d = pick;
                    last_d  = pick;
                    cnt_d   = TMO_W'(1);
                end
            end
            ST_BUSY: begin
                if (!(req_s[owner_q] && pres_s[owner_q])) begin
                    state_d = ST_GAP1;
                end else if (cnt_q >= eff_lim) begin
                    state_d         = ST_GAP1;
                    flag_d[owner_q] = 1'b1;
                end else begin
                    cnt_d = cnt_q + TMO_W'(1);
                end
            end
            ST_GAP1: state_d = ST_GAP2;
            ST_GAP2: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            owner_q <= '0;
            last_q  <= LAST_INIT;
            cnt_q   <= '0;
            flag_q  <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            last_q  <= last_d;
            cnt_q   <= cnt_d;
            flag_q  <= flag_d;
        end
    end

    always_comb begin
        sel_n    = '1;
        tmo_flag = flag_q;
        if (state_q == ST_BUSY) begin
            sel_n[owner_q] = 1'b0;
        end
    end

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~sel_n) <= 1) else $error("more than one select low"); // R3

    AST_SLOT0_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n[0] == 1'b1) else $error("slot 0 selected"); // R5

    AST_PRESENT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel_n) == '1 && sel_n != '1) |-> ((~sel_n & ~$past(pres_s)) == '0))
        else $error("absent slot granted"); // R4

    AST_GUARD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel_n) != '1 && sel_n == '1) |=> (sel_n == '1))
        else $error("guard gap too short"); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((tmo_flag & $past(tmo_flag)) == $past(tmo_flag)))
        else $error("timeout flag cleared"); // R9

    AST_FLAG_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_flag != $past(tmo_flag)) |-> (sel_n == '1 && $past(sel_n) != '1))
        else $error("timeout flag set outside withdrawal"); // R9
endmodule

// File: tb/test_slot_bus_arbiter.sv
module test_slot_bus_arbiter;
    localparam int  NS       = 8;
    localparam int  TW       = 16;
    localparam time CLK_HALF = 5ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] req_n = '1;
    logic [NS-1:0] pres_n = '0;
    logic [TW-1:0] hold_limit = 16'd20;
    logic [NS-1:0] sel_n, tmo_flag;

    slot_bus_arbiter #(.NSLOT(NS), .TMO_W(TW)) i_slot_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .pres_n(pres_n),
        .hold_limit(hold_limit), .sel_n(sel_n), .tmo_flag(tmo_flag)
    );

    always #CLK_HALF clk = ~clk;

    int errors = 0;
    int checks = 0;
    int pcyc   = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, pcyc);
        end
    endtask

    // behavioural reference model
    logic [NS-1:0] m_r1, m_r2, m_p1, m_p2, m_flag;
    int m_st, m_own, m_last, m_cnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_r1 = '0; m_r2 = '0; m_p1 = '0; m_p2 = '0; m_flag = '0;
            m_st = 0; m_own = 0; m_last = NS - 1; m_cnt = 0;
        end else begin
            int lim;
            pcyc++;
            lim = (hold_limit == 0) ? 1 : int'(hold_limit);
            case (m_st)
                0: begin
                    for (int k = 1; k < NS; k++) begin
                        int c;
                        c = ((m_last - 1 + k) % (NS - 1)) + 1;
                        if (m_st == 0 && m_r2[c] && m_p2[c]) begin
                            m_st = 1; m_own = c; m_last = c; m_cnt = 1;
                        end
                    end
                end
                1: begin
                    if (!(m_r2[m_own] && m_p2[m_own])) m_st = 2;
                    else if (m_cnt >= lim) begin m_st = 2; m_flag[m_own] = 1'b1; end
                    else m_cnt++;
                end
                2: m_st = 3;
                default: m_st = 0;
            endcase
            m_r2 = m_r1; m_r1 = ~req_n;
            m_p2 = m_p1; m_p1 = ~pres_n;
        end
    end

    // card behaviour and observers
    bit  act[NS];
    int  held[NS], len[NS], last_run[NS], gcount[NS];
    bit  was_low[NS];
    int  glog[$];
    int  grant_cyc = -1;
    int  run = 0, gap = 0, min_gap = 1000;
    bit  seen_grant = 0;
    logic [NS-1:0] prev_sel = '1;

    always @(negedge clk) begin
        if (rst_n) begin
            logic [NS-1:0] m_sel;
            m_sel = (m_st == 1) ? ~(NS'(1) << m_own) : '1;
            check(sel_n == m_sel, "R2 R3 R6 R7 sel_n vs model", int'(sel_n), int'(m_sel));
            check(tmo_flag == m_flag, "R9 tmo_flag vs model", int'(tmo_flag), int'(m_flag));
        end
        if (prev_sel == '1 && sel_n != '1) begin
            for (int i = 0; i < NS; i++) if (!sel_n[i]) begin
                glog.push_back(i); gcount[i]++;
            end
            grant_cyc = pcyc;
            if (seen_grant && gap < min_gap) min_gap = gap;
            seen_grant = 1; run = 0;
        end
        if (sel_n != '1) begin
            run++; gap = 0;
        end else begin
            if (prev_sel != '1)
                for (int i = 0; i < NS; i++) if (!prev_sel[i]) last_run[i] = run;
            gap++;
        end
        for (int i = 1; i < NS; i++) begin
            if (act[i]) begin
                if (!sel_n[i]) begin
                    held[i]++; was_low[i] = 1;
                    if (held[i] >= len[i]) begin req_n[i] = 1'b1; act[i] = 0; end
                end else if (was_low[i]) begin
                    req_n[i] = 1'b1; act[i] = 0;
                end
            end
        end
        prev_sel = sel_n;
    end

    task automatic start_card(input int s, input int l);
        act[s] = 1; held[s] = 0; was_low[s] = 0; len[s] = l; req_n[s] = 1'b0;
    endtask

    task automatic wait_quiet();
        int n = 0;
        do begin
            @(negedge clk); n++;
        end while (n < 5000 && !(sel_n == '1 && gap > 6 &&
                   !act[1] && !act[2] && !act[3] && !act[4] && !act[6] && !act[7]));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int p0;
        repeat (3) @(negedge clk);
        check(sel_n == '1, "R1 sel_n in reset", int'(sel_n), 8'hFF);
        check(tmo_flag == '0, "R1 tmo_flag in reset", int'(tmo_flag), 0);
        rst_n = 1'b1;
        pres_n = 8'b0010_0000;          // slot 5 absent
        req_n[0] = 1'b0;                // bus master slot requests: R5
        req_n[5] = 1'b0;                // absent slot requests: R4
        repeat (4) @(negedge clk);
        check(sel_n == '1, "R1 R4 R5 no grant yet", int'(sel_n), 8'hFF);

        // A: slots 1,3,6 at once, first after reset must be slot 1
        p0 = pcyc;
        start_card(3, 4); start_card(6, 4); start_card(1, 4);
        wait_quiet();
        check(grant_cyc - p0 >= 0, "R2 grant observed", grant_cyc, p0);
        check(glog.size() == 3, "R6 grant count A", glog.size(), 3);
        if (glog.size() == 3) begin
            check(glog[0] == 1, "R1 R6 first slot", glog[0], 1);
            check(glog[1] == 3, "R6 second slot", glog[1], 3);
            check(glog[2] == 6, "R6 third slot", glog[2], 6);
        end
        check(last_run[1] == 6, "R7 release latency run", last_run[1], 6);

        // R2: latency of a lone request on an idle arbiter
        glog.delete();
        p0 = pcyc;
        start_card(2, 2);
        wait_quiet();
        check(glog.size() == 1 && glog[0] == 2, "R2 lone grant slot", glog.size(), 1);

        // B: wrap from slot 2 -> 7? requests 1,7 and 4: order 4,7,1
        glog.delete();
        start_card(1, 3); start_card(7, 3); start_card(4, 3);
        wait_quiet();
        check(glog.size() == 3, "R6 grant count B", glog.size(), 3);
        if (glog.size() == 3) begin
            check(glog[0] == 4, "R6 B first", glog[0], 4);
            check(glog[1] == 7, "R6 B second", glog[1], 7);
            check(glog[2] == 1, "R6 B wrap", glog[2], 1);
        end

        // C: timeout on slot 4, limit 10
        hold_limit = 16'd10;
        start_card(4, 1000);
        wait_quiet();
        check(last_run[4] == 10, "R9 hold length at limit", last_run[4], 10);
        check(tmo_flag == 8'h10, "R9 flag for slot 4", int'(tmo_flag), 8'h10);

        // D: limit 0 behaves as 1
        hold_limit = 16'd0;
        start_card(3, 1000);
        wait_quiet();
        check(last_run[3] == 1, "R9 zero limit run", last_run[3], 1);
        check(tmo_flag == 8'h18, "R9 flags sticky", int'(tmo_flag), 8'h18);

        // E: presence lost during a grant
        hold_limit = 16'd200;
        start_card(2, 1000);
        while (sel_n[2]) @(negedge clk);
        repeat (5) @(negedge clk);
        pres_n[2] = 1'b1;
        repeat (12) @(negedge clk);
        check(sel_n == '1, "R4 grant dropped on absence", int'(sel_n), 8'hFF);
        check(last_run[2] == 8, "R4 run until absence seen", last_run[2], 8);
        check(tmo_flag == 8'h18, "R9 no flag on absence", int'(tmo_flag), 8'h18);
        act[2] = 0; req_n[2] = 1'b1;
        repeat (10) @(negedge clk);
        check(sel_n == '1, "R4 absent slot 2 not regranted", int'(sel_n), 8'hFF);
        pres_n[2] = 1'b0;

        // F: summary properties
        check(gcount[0] == 0, "R5 slot 0 grants", gcount[0], 0);
        check(gcount[5] == 0, "R4 absent slot 5 grants", gcount[5], 0);
        check(min_gap >= 2, "R8 minimum guard gap", min_gap, 2);
        check(min_gap == 3, "R8 guard gap length", min_gap, 3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule